// File: doc/BRIEF.md
# Four-Mode Logic Block Observer Register

A register of `WIDTH` flip-flops that sits between two blocks of combinational logic. Two mode-select inputs choose its function. In the first function it is an ordinary parallel register. In the second it is a serial scan chain. In the third it is a free-running pseudorandom pattern source. In the fourth it is a multi-input signature compactor. All the self-test functions share one feedback path, built from the characteristic polynomial 1 + x + x^WIDTH. A test controller drives the mode pins. In one phase it makes one such register generate stimulus and a neighbouring register compact the responses. In the next phase it can swap the two roles.

The register has no reset net. It is cleared by shifting zeros through the scan chain. It is seeded the same way, or by a parallel capture. An all-zero state is a fixed point of the pattern generator, so a nonzero seed must be loaded before generation starts.

Top module: `bilbo_reg`

## Requirements
- R1: With mode `{mode_msb,mode_lsb}` = 00 (shift), each edge moves `scan_in` into stage 0 (`par_out[0]`) and moves stage i-1 into stage i. After WIDTH shifts, the first bit shifted in sits at `par_out[WIDTH-1]`.
- R2: WIDTH consecutive shift edges with `scan_in` = 0 leave `par_out` all zero, whatever the earlier contents.
- R3: With mode 10 (capture), each edge loads `par_in` into `par_out` bit for bit.
- R4: With mode 01 (generate), the next state is stage 0 = `par_out[WIDTH-1]` XOR `par_out[0]` and stage i = old stage i-1. `par_in` and `scan_in` have no effect.
- R5: In generate mode an all-zero state stays all zero.
- R6: For WIDTH = 3, generate mode started from a nonzero state visits all 7 nonzero states and returns to the start after exactly 7 edges.
- R7: With mode 11 (compact), the next state is the generate-mode next state XOR `par_in`.
- R8: Compaction is linear. Starting from zero, the signature of the bitwise XOR of two input streams equals the XOR of the two separate signatures.
- R9: `scan_out` equals the last stage `par_out[WIDTH-1]` in every mode.
- R10: A mode change applies from the next edge. The state already held is the operand of the new mode, with no lost or extra cycle.
- R11: Two registers joined through combinational logic can swap generator and compactor roles between phases. Each phase ends with the signature predicted by R4 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| mode_msb | input | 1 | Upper mode-select bit |
| mode_lsb | input | 1 | Lower mode-select bit |
| par_in | input | WIDTH | Parallel data from the preceding logic |
| scan_in | input | 1 | Serial input into stage 0 |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Last stage of the chain |

## Verification
The full state is visible on `par_out` at all times. A wrong next-state bit therefore appears at the ports on the edge right after the faulty step, in every mode. A fault in the feedback tap shows only in generate or compact mode. In compact mode it also feeds forward, so the final signature differs from the prediction, and it keeps differing unless a later input happens to cancel the error. The sweeps cover every start state with every input word for one compaction step, and the full 7-state cycle of the 3-bit generator, so a single wrong tap or a wrong cell mux is caught within a few cycles.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    typedef enum logic [1:0] {
        BL_SHIFT   = 2'b00,
        BL_PRPG    = 2'b01,
        BL_CAPTURE = 2'b10,
        BL_COMPACT = 2'b11
    } bl_mode_e;

    // Per-cell control derived from the mode
    typedef struct packed {
        logic take_par;   // load parallel bit directly
        logic mix_par;    // XOR parallel bit into serial bit
        logic head_scan;  // stage 0 takes scan_in instead of feedback
    } bl_ctl_t;

    function automatic bl_ctl_t bl_decode(input bl_mode_e m);
        bl_ctl_t c;
        c.take_par  = (m == BL_CAPTURE);
        c.mix_par   = (m == BL_COMPACT);
        c.head_scan = (m == BL_SHIFT);
        return c;
    endfunction

    // Feedback for 1 + x + x^n: last stage XOR first stage
    function automatic logic bl_feedback(input logic last_bit, input logic first_bit);
        return last_bit ^ first_bit;
    endfunction

endpackage

// File: rtl/bilbo_ctl.sv
module bilbo_ctl
    import bilbo_pkg::*;
(
    input  logic    mode_msb,
    input  logic    mode_lsb,
    output bl_ctl_t ctl
);
    bl_mode_e mode;

    always_comb begin
        mode = bl_mode_e'({mode_msb, mode_lsb});
        ctl  = bl_decode(mode);
    end
endmodule

// File: rtl/bilbo_head.sv
module bilbo_head
    import bilbo_pkg::*;
(
    input  logic scan_in,
    input  logic q_last,
    input  logic q_first,
    input  logic head_scan,
    output logic ser_head
);
    always_comb begin
        if (head_scan) ser_head = scan_in;
        else           ser_head = bl_feedback(q_last, q_first);
    end
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
    import bilbo_pkg::*;
(
    input  logic    clk,
    input  bl_ctl_t ctl,
    input  logic    par_bit,
    input  logic    ser_bit,
    output logic    q
);
    logic d_next;

    always_comb begin
        if (ctl.take_par) d_next = par_bit;
        else              d_next = ser_bit ^ (ctl.mix_par & par_bit);
    end

    always_ff @(posedge clk) begin
        q <= d_next;
    end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mode_msb,
    input  logic             mode_lsb,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    localparam int LAST = WIDTH - 1;

    bl_ctl_t          ctl;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] ser;

    bilbo_ctl u_ctl (
        .mode_msb (mode_msb),
        .mode_lsb (mode_lsb),
        .ctl      (ctl)
    );

    bilbo_head u_head (
        .scan_in   (scan_in),
        .q_last    (q[LAST]),
        .q_first   (q[0]),
        .head_scan (ctl.head_scan),
        .ser_head  (ser[0])
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i > 0) begin : g_link
            assign ser[i] = q[i-1];
        end
        bilbo_cell u_cell (
            .clk     (clk),
            .ctl     (ctl),
            .par_bit (par_in[i]),
            .ser_bit (ser[i]),
            .q       (q[i])
        );
    end

    assign par_out  = q;
    assign scan_out = q[LAST];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mode_msb,
    input logic             mode_lsb,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] par_out
);
    localparam int unsigned FILL_MAX = WIDTH - 1;

    logic [1:0]  mode;
    int unsigned fill;
    logic        armed;

    assign mode = {mode_msb, mode_lsb};

    initial begin
        fill  = 0;
        armed = 1'b0;
    end

    // State is defined only once a full scan has passed through
    always @(posedge clk) begin
        if (mode == 2'b00) begin
            if (fill >= FILL_MAX) armed <= 1'b1;
            else                  fill  <= fill + 1;
        end else begin
            fill <= 0;
        end
    end

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b00) |=> par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)}); // R1

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b10) |=> par_out == $past(par_in)); // R3

    AST_PRPG_STEP: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b01) |=> par_out ==
            {$past(par_out[WIDTH-2:0]), $past(par_out[WIDTH-1] ^ par_out[0])}); // R4

    AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b01 && par_out == '0) |=> par_out == '0); // R5

    AST_COMPACT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b11) |=> par_out ==
            ({$past(par_out[WIDTH-2:0]), $past(par_out[WIDTH-1] ^ par_out[0])} ^ $past(par_in))); // R7
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .mode_msb (mode_msb),
    .mode_lsb (mode_lsb),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out)
);

// File: tb/bilbo_reg_tb.sv
`timescale 1ns/1ps
module bilbo_reg_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // single 3-bit register
    logic [1:0] m;
    logic [2:0] pin;
    logic       si;
    logic [2:0] pout;
    logic       so;

    bilbo_reg #(.WIDTH(3)) u_dut (
        .clk(clk), .mode_msb(m[1]), .mode_lsb(m[0]),
        .par_in(pin), .scan_in(si), .par_out(pout), .scan_out(so)
    );

    // pair of 4-bit registers around a stub
    logic [1:0] ma, mb;
    logic       sia, sib;
    logic [3:0] a_out, b_out, a_in, b_in;
    logic       a_so, b_so;

    function automatic logic [3:0] a2b(input logic [3:0] x);
        return {x[3] ^ x[0], x[2] & x[1], ~x[1], x[3] | x[2]};
    endfunction
    function automatic logic [3:0] b2a(input logic [3:0] x);
        return {x[0], x[3] ^ x[2], x[1], ~x[3]};
    endfunction

    assign b_in = a2b(a_out);
    assign a_in = b2a(b_out);

    bilbo_reg #(.WIDTH(4)) u_pa (
        .clk(clk), .mode_msb(ma[1]), .mode_lsb(ma[0]),
        .par_in(a_in), .scan_in(sia), .par_out(a_out), .scan_out(a_so)
    );
    bilbo_reg #(.WIDTH(4)) u_pb (
        .clk(clk), .mode_msb(mb[1]), .mode_lsb(mb[0]),
        .par_in(b_in), .scan_in(sib), .par_out(b_out), .scan_out(b_so)
    );

    // Next state per requirements R1, R3, R4, R7 (bit 0 = first stage)
    function automatic logic [7:0] model(input int n, input logic [1:0] md,
                                         input logic [7:0] q, input logic [7:0] d,
                                         input logic s);
        logic [7:0] mask, sh;
        logic       fb;
        mask = 8'((9'h1 << n) - 1);
        fb   = q[n-1] ^ q[0];
        sh   = (q << 1) & mask;
        case (md)
            2'b00:   return sh | {7'd0, s};
            2'b01:   return sh | {7'd0, fb};
            2'b10:   return d & mask;
            default: return (sh | {7'd0, fb}) ^ (d & mask);
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [1:0] md, input logic [2:0] d, input logic s);
        m = md; pin = d; si = s;
        tick();
    endtask

    task automatic clear3();
        for (int k = 0; k < 3; k++) run(2'b00, 3'd0, 1'b0);
    endtask

    logic [7:0] ea, eb;
    task automatic run_pair(input logic [1:0] xa, input logic [1:0] xb,
                            input logic s_a, input logic s_b);
        logic [7:0] na, nb;
        ma = xa; mb = xb; sia = s_a; sib = s_b;
        na = model(4, xa, ea, {4'd0, b2a(eb[3:0])}, s_a);
        nb = model(4, xb, eb, {4'd0, a2b(ea[3:0])}, s_b);
        tick();
        ea = na; eb = nb;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] e, sx, sy, sz, start;
        logic [7:0] seen;
        logic [1:0] xs [4];
        logic [2:0] xw [4];
        logic [2:0] yw [4];
        m = 2'b00; pin = '0; si = 1'b0;
        ma = 2'b00; mb = 2'b00; sia = 1'b0; sib = 1'b0;
        @(negedge clk);

        // R2: clear by shifting zeros after loading ones
        run(2'b10, 3'b111, 1'b0);
        clear3();
        check("R2 clear", {5'd0, pout}, 8'd0);
        check("R9 scan_out after clear", {7'd0, so}, 8'd0);

        // R1 / R9: shift sweep over all patterns
        for (int v = 0; v < 8; v++) begin
            run(2'b00, 3'd5, v[0]);
            run(2'b00, 3'd2, v[1]);
            run(2'b00, 3'd7, v[2]);
            check("R1 shift in", {5'd0, pout}, {5'd0, v[0], v[1], v[2]});
            for (int k = 0; k < 3; k++) begin
                check("R9 shift out", {7'd0, so}, {7'd0, v[k]});
                run(2'b00, 3'd0, 1'b0);
            end
            check("R2 zeros after shift out", {5'd0, pout}, 8'd0);
        end

        // R3: capture sweep
        for (int v = 0; v < 8; v++) begin
            run(2'b10, 3'(v), ~v[0]);
            check("R3 capture", {5'd0, pout}, 8'(v));
        end

        // R4 / R6: generator from 001, par_in and scan_in toggled
        run(2'b10, 3'b001, 1'b0);
        e = 8'd1; start = 8'd1; seen = 8'd0;
        for (int k = 0; k < 7; k++) begin
            e = model(3, 2'b01, e, 8'd0, 1'b0);
            run(2'b01, 3'(k * 3 + 5), k[0]);
            check("R4 generate step", {5'd0, pout}, e);
            if (k < 6) check("R6 no early repeat", {7'd0, pout == 3'(start)}, 8'd0);
            seen[pout] = 1'b1;
        end
        check("R6 period 7", {5'd0, pout}, start);
        check("R6 all nonzero visited", seen, 8'hFE);

        // R5: zero lock-up
        run(2'b10, 3'b000, 1'b0);
        for (int k = 0; k < 5; k++) begin
            run(2'b01, 3'b111, 1'b1);
            check("R5 zero stays zero", {5'd0, pout}, 8'd0);
        end

        // R7: every start state against every input word
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                run(2'b10, 3'(s), 1'b0);
                run(2'b11, 3'(d), 1'b1);
                check("R7 compact step", {5'd0, pout}, model(3, 2'b11, 8'(s), 8'(d), 1'b0));
            end
        end

        // R8: linearity of compaction
        xw[0] = 3'd5; xw[1] = 3'd3; xw[2] = 3'd6; xw[3] = 3'd1;
        yw[0] = 3'd2; yw[1] = 3'd7; yw[2] = 3'd4; yw[3] = 3'd6;
        clear3();
        e = 8'd0;
        for (int k = 0; k < 4; k++) begin
            e = model(3, 2'b11, e, {5'd0, xw[k]}, 1'b0);
            run(2'b11, xw[k], 1'b0);
        end
        sx = {5'd0, pout};
        check("R8 signature of first stream", sx, e);
        clear3();
        for (int k = 0; k < 4; k++) run(2'b11, yw[k], 1'b0);
        sy = {5'd0, pout};
        clear3();
        for (int k = 0; k < 4; k++) run(2'b11, xw[k] ^ yw[k], 1'b0);
        sz = {5'd0, pout};
        check("R8 superposition", sz, sx ^ sy);

        // R10 / R9: mode changes every edge
        run(2'b10, 3'b101, 1'b0);
        e = 8'd5;
        xs[0] = 2'b01; xs[1] = 2'b11; xs[2] = 2'b00; xs[3] = 2'b10;
        for (int k = 0; k < 16; k++) begin
            logic [1:0] md;
            logic [2:0] dw;
            logic       sb;
            md = xs[(k * 3 + k / 4) % 4];
            dw = 3'(k * 5 + 1);
            sb = k[0] ^ k[2];
            e = model(3, md, e, {5'd0, dw}, sb);
            run(md, dw, sb);
            check("R10 mode switch step", {5'd0, pout}, e);
            check("R9 scan_out is last stage", {7'd0, so}, {7'd0, pout[2]});
        end

        // R11: role swap between two registers
        ea = 8'd0; eb = 8'd0;
        for (int k = 0; k < 4; k++) run_pair(2'b00, 2'b00, 1'b0, 1'b0);
        check("R11 pair cleared", {a_out, b_out}, 8'd0);
        run_pair(2'b00, 2'b00, 1'b1, 1'b0);
        run_pair(2'b00, 2'b00, 1'b0, 1'b0);
        run_pair(2'b00, 2'b00, 1'b1, 1'b0);
        run_pair(2'b00, 2'b00, 1'b1, 1'b0);
        check("R11 seed A", {4'd0, a_out}, ea);
        for (int k = 0; k < 12; k++) run_pair(2'b01, 2'b11, 1'b0, 1'b0);
        check("R11 phase1 generator A", {4'd0, a_out}, ea);
        check("R11 phase1 signature B", {4'd0, b_out}, eb);
        for (int k = 0; k < 12; k++) run_pair(2'b11, 2'b01, 1'b0, 1'b0);
        check("R11 phase2 signature A", {4'd0, a_out}, ea);
        check("R11 phase2 generator B", {4'd0, b_out}, eb);
        check("R11 scan_out A", {7'd0, a_so}, {7'd0, ea[3]});
        check("R11 scan_out B", {7'd0, b_so}, {7'd0, eb[3]});

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule